// File: doc/BRIEF.md
# Sign-Magnitude Multiplier

This block multiplies two signed operands and returns the product in sign-magnitude form. Operand A is WA bits wide and operand B is WB bits wide. Each operand holds one sign bit at its top and a magnitude field below it. The product magnitude is the plain unsigned product of the two magnitude fields. The product sign is the exclusive-or of the two operand signs. The result word is the sign bit placed directly above that magnitude. No bits are lost, so the result is exactly one bit narrower than WA+WB.

A format input selects how the operand codes are read. With the format input low, the codes are taken as sign-magnitude. With it high, they are taken as two's complement and are first turned into sign-magnitude by a small front-end. A parameter picks the magnitude multiplier structure: either an explicit shift-and-add array of partial products, or the plain multiply operator. The result is captured in one output register, so a pair of operands yields its product one clock later.

Top module: `sm_mult`

## Requirements
- R1: `prod_out` is WA+WB-1 bits wide. Bit WA+WB-2 is the sign, and bits WA+WB-3..0 are the magnitude. With the defaults (WA=4, WB=5), A=4'b1011 (minus three) times B=5'b10110 (minus six) in sign-magnitude format gives 8'b0001_0010 (plus eighteen).
- R2: With `fmt_twos`=0, the top bit of each operand is its sign and the remaining bits are its magnitude. The result magnitude equals the unsigned product of the two magnitudes.
- R3: Whenever the product magnitude is nonzero, the result sign equals the exclusive-or of the two operand signs.
- R4: Whenever the product magnitude is zero, the result sign is 0. This includes inputs that are negative zero, such as A=4'b1000 in sign-magnitude format.
- R5: With `fmt_twos`=1, each operand is read as two's complement. A non-negative code keeps its low bits as the magnitude. A negative code takes its negation as the magnitude, and its sign is 1.
- R6: With `fmt_twos`=1, the most negative code (a 1 followed by all zeros) has a magnitude that does not fit the field. It is read as sign 1 with an all-ones magnitude. For example, A=4'b1000 times B=5'b00011 gives 8'b1001_0101.
- R7: `prod_out` changes only on the rising edge of `clk`, and it shows the result for the operands present at that edge. While `rst_n` is low, `prod_out` is 0.
- R8: The shift-and-add multiplier structure (ARCH=1) and the operator structure (ARCH=0) give identical results for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the result |
| fmt_twos | input | 1 | Operand format: 0 = sign-magnitude, 1 = two's complement |
| a_in | input | WA | Operand A code |
| b_in | input | WB | Operand B code |
| prod_out | output | WA+WB-1 | Sign-magnitude product: sign on top, magnitude below |

## Verification
Every product is due exactly one rising edge after its operands are presented, because the only register on the path is the output register. The bench drives operands on a falling edge and samples `prod_out` on the next falling edge, half a period after the capturing edge. One directed check reads the output just before that edge, to confirm that the old value is still held, and again just after it. The checker properties relate each result to the operands sampled one cycle earlier, using a single-cycle past reference. The bench covers every operand pair in both formats at the default widths, then adds seeded random pairs.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;

    // Operand code interpretation
    typedef enum logic {
        FMT_SIGNMAG = 1'b0,
        FMT_TWOS    = 1'b1
    } opnd_fmt_e;

    // Magnitude multiplier structure selectors
    localparam int MULT_OPERATOR = 0;
    localparam int MULT_SHIFTADD = 1;

endpackage

// File: rtl/sm_operand_cvt.sv
module sm_operand_cvt
    import sm_mult_pkg::*;
#(
    parameter int W = 4
) (
    input  opnd_fmt_e      fmt,
    input  logic [W-1:0]   code,
    output logic           sign,
    output logic [W-2:0]   mag
);
    localparam int MW = W - 1;

    logic [MW-1:0] neg_mag;
    logic          is_min;

    // Low bits of the two's complement negation of a negative code
    assign neg_mag = (~code[MW-1:0]) + {{(MW-1){1'b0}}, 1'b1};
    // Most negative code: its magnitude cannot fit in MW bits
    assign is_min  = code[W-1] & ~(|code[MW-1:0]);

    always_comb begin
        sign = code[W-1];
        mag  = code[MW-1:0];
        if (fmt == FMT_TWOS && code[W-1]) begin
            mag = is_min ? {MW{1'b1}} : neg_mag;
        end
    end

endmodule

// File: rtl/sm_mag_mult.sv
module sm_mag_mult
    import sm_mult_pkg::*;
#(
    parameter int MA   = 3,
    parameter int MB   = 4,
    parameter int ARCH = MULT_SHIFTADD
) (
    input  logic [MA-1:0]    a,
    input  logic [MB-1:0]    b,
    output logic [MA+MB-1:0] p
);
    localparam int P = MA + MB;

    logic [P-1:0] a_wide;
    assign a_wide = {{MB{1'b0}}, a};

    generate
        if (ARCH == MULT_OPERATOR) begin : g_operator
            assign p = a_wide * {{MA{1'b0}}, b};
        end else begin : g_shiftadd
            // Running sum of the shifted partial products, one per B bit
            logic [P-1:0] acc [MB+1];
            assign acc[0] = '0;
            for (genvar i = 0; i < MB; i++) begin : g_row
                assign acc[i+1] = acc[i] + (b[i] ? (a_wide << i) : {P{1'b0}});
            end
            assign p = acc[MB];
        end
    endgenerate

endmodule

// File: rtl/sm_mult.sv
module sm_mult
    import sm_mult_pkg::*;
#(
    parameter int WA   = 4,
    parameter int WB   = 5,
    parameter int ARCH = MULT_SHIFTADD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_twos,
    input  logic [WA-1:0]       a_in,
    input  logic [WB-1:0]       b_in,
    output logic [WA+WB-2:0]    prod_out
);
    localparam int MA = WA - 1;
    localparam int MB = WB - 1;
    localparam int MW = MA + MB;

    typedef struct packed {
        logic          sign;
        logic [MW-1:0] mag;
    } prod_t;

    opnd_fmt_e     fmt;
    logic          sign_a, sign_b;
    logic [MA-1:0] mag_a;
    logic [MB-1:0] mag_b;
    logic [MW-1:0] mag_p;
    prod_t         prod_d, prod_q;

    assign fmt = opnd_fmt_e'(fmt_twos);

    sm_operand_cvt #(.W(WA)) u_cvt_a (
        .fmt  (fmt),
        .code (a_in),
        .sign (sign_a),
        .mag  (mag_a)
    );

    sm_operand_cvt #(.W(WB)) u_cvt_b (
        .fmt  (fmt),
        .code (b_in),
        .sign (sign_b),
        .mag  (mag_b)
    );

    sm_mag_mult #(.MA(MA), .MB(MB), .ARCH(ARCH)) u_mag_mult (
        .a (mag_a),
        .b (mag_b),
        .p (mag_p)
    );

    always_comb begin
        prod_d.mag  = mag_p;
        // A zero magnitude always carries a positive sign
        prod_d.sign = (sign_a ^ sign_b) & (|mag_a) & (|mag_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else begin
            prod_q <= prod_d;
        end
    end

    assign prod_out = prod_q;

endmodule

// File: rtl/sm_mult_chk.sv
module sm_mult_chk #(
    parameter int WA = 4,
    parameter int WB = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fmt_twos,
    input logic [WA-1:0]    a_in,
    input logic [WB-1:0]    b_in,
    input logic [WA+WB-2:0] prod_out
);
    localparam int MW = WA + WB - 2;
    localparam logic [MW-1:0] AMAX = MW'((1 << (WA - 1)) - 1);

    logic [MW-1:0] a_ext, b_ext;
    assign a_ext = MW'(a_in[WA-2:0]);
    assign b_ext = MW'(b_in[WB-2:0]);

    // R4: a zero magnitude never carries a negative sign
    assert_zero_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_out[MW-1:0] == '0) |-> !prod_out[MW]);

    // R2: sign-magnitude operands give the product of their magnitude fields
    assert_sm_mag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_twos |=> prod_out[MW-1:0] == $past(a_ext) * $past(b_ext));

    // R3: nonzero product sign is the exclusive-or of the operand signs
    assert_sign_xor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_twos && (|a_in[WA-2:0]) && (|b_in[WB-2:0]))
        |=> prod_out[MW] == $past(a_in[WA-1] ^ b_in[WB-1]));

    // R5: non-negative two's complement operands multiply unchanged
    assert_twos_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_twos && !a_in[WA-1] && !b_in[WB-1])
        |=> prod_out == {1'b0, $past(a_ext) * $past(b_ext)});

    // R6: most negative A code acts as an all-ones magnitude
    assert_min_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_twos && a_in == {1'b1, {(WA-1){1'b0}}} && !b_in[WB-1])
        |=> prod_out[MW-1:0] == AMAX * $past(b_ext));

endmodule

bind sm_mult sm_mult_chk #(.WA(WA), .WB(WB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_twos (fmt_twos),
    .a_in     (a_in),
    .b_in     (b_in),
    .prod_out (prod_out)
);

// File: tb/sm_mult_tb.sv
module sm_mult_tb;
    localparam int WA = 4;
    localparam int WB = 5;
    localparam int OW = WA + WB - 1;
    localparam int MW = OW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_twos = 1'b0;
    logic [WA-1:0] a_in = '0;
    logic [WB-1:0] b_in = '0;
    logic [OW-1:0] prod_out, prod_out_op;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sm_mult #(.WA(WA), .WB(WB), .ARCH(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos),
        .a_in(a_in), .b_in(b_in), .prod_out(prod_out)
    );

    sm_mult #(.WA(WA), .WB(WB), .ARCH(0)) u_dut_op (
        .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos),
        .a_in(a_in), .b_in(b_in), .prod_out(prod_out_op)
    );

    task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic int ref_mag(input int code, input int w, input bit twos);
        int mask = (1 << (w - 1)) - 1;
        int m;
        if (!twos || ((code >> (w - 1)) & 1) == 0) return code & mask;
        m = (1 << w) - code;
        if (m > mask) m = mask;
        return m;
    endfunction

    function automatic logic [OW-1:0] ref_prod(input bit twos, input int a, input int b);
        int sa = (a >> (WA - 1)) & 1;
        int sb = (b >> (WB - 1)) & 1;
        int p  = ref_mag(a, WA, twos) * ref_mag(b, WB, twos);
        logic [OW-1:0] r;
        r = OW'(p);
        r[MW] = (p != 0) ? 1'(sa ^ sb) : 1'b0;
        return r;
    endfunction

    function automatic string tag_for(input bit twos, input int a, input int b);
        if (ref_mag(a, WA, twos) == 0 || ref_mag(b, WB, twos) == 0) return "R4 zero sign";
        if (twos && (a == (1 << (WA - 1)) || b == (1 << (WB - 1)))) return "R6 most negative";
        if (twos) return "R5 twos conversion";
        if ((((a >> (WA - 1)) ^ (b >> (WB - 1))) & 1) != 0) return "R3 sign xor";
        return "R2 magnitude product";
    endfunction

    task automatic apply(input bit twos, input int a, input int b);
        logic [OW-1:0] exp;
        @(negedge clk);
        fmt_twos = twos;
        a_in     = WA'(a);
        b_in     = WB'(b);
        exp      = ref_prod(twos, a, b);
        @(negedge clk);
        check(tag_for(twos, a, b), prod_out, exp);
        check("R8 structure match", prod_out_op, exp);
    endtask

    initial begin
        // R7: output held at zero during reset despite live operands
        a_in = 4'b0011;
        b_in = 5'b00101;
        repeat (3) @(negedge clk);
        check("R7 reset value", prod_out, '0);
        rst_n = 1'b1;

        // R1: width and worked example
        check("R1 width", OW'($bits(prod_out)), OW'(WA + WB - 1));
        apply(1'b0, 4'b1011, 5'b10110);
        check("R1 example", prod_out, 8'b0001_0010);

        // Directed corners
        apply(1'b0, 4'b1000, 5'b10101);
        check("R4 negative zero", prod_out, 8'b0000_0000);
        apply(1'b1, 4'b1000, 5'b00011);
        check("R6 saturated", prod_out, 8'b1001_0101);
        apply(1'b1, 4'b1101, 5'b11010);
        check("R5 twos example", prod_out, 8'b0001_0010);
        apply(1'b1, 4'b1000, 5'b10000);
        check("R6 both most negative", prod_out, 8'b0110_1001);

        // R7: latency of one rising edge
        @(negedge clk);
        fmt_twos = 1'b0;
        a_in = 4'b0010;
        b_in = 5'b00011;
        @(posedge clk);
        #0;
        @(negedge clk);
        check("R7 after edge", prod_out, 8'b0000_0110);
        a_in = 4'b0101;
        b_in = 5'b00111;
        #3;
        check("R7 held before edge", prod_out, 8'b0000_0110);
        @(posedge clk);
        #1;
        check("R7 updated at edge", prod_out, 8'b0010_0011);

        // Every operand pair in both formats
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < (1 << WA); a++) begin
                for (int b = 0; b < (1 << WB); b++) begin
                    apply(f[0], a, b);
                end
            end
        end

        // Seeded random pairs
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 300; k++) begin
            int ra = int'($urandom % (1 << WA));
            int rb = int'($urandom % (1 << WB));
            bit rf = 1'($urandom % 2);
            apply(rf, ra, rb);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule